// File: doc/BRIEF.md
# Strobed Serial Register-Access Target

This block is the target end of a four-wire bit-serial register link. A host moves a strobe and a serial data input, and it can pulse an active-low clear line. The target answers on a serial data output. Each transaction is one 24-bit frame. The first bit selects read or write. The next seven bits give a register address. The last sixteen bits carry the data word. For a write, the target samples the word from the host. For a read, the target drives the addressed register back to the host on the falling strobe edges. A 25th rising strobe edge acknowledges the frame. On a write, that same edge also commits the word into the register bank.

The strobe is treated as an asynchronous pin. It passes through a two-flop synchronizer in the system clock domain, and an edge detector turns it into single-cycle rise and fall events. The clear input and the data input are sampled directly in the clock domain. A frame sequencer with four named states tracks the frame:

- `ST_HDR` collects the flag and the address.
- `ST_WR` collects write data.
- `ST_RD` drives read data.
- `ST_ACK` waits for the acknowledging edge.

The transitions are:

- HDR→WR: the eighth rise, when the flag is 0.
- HDR→RD: the eighth rise, when the flag is 1.
- WR→ACK and RD→ACK: the 24th rise.
- ACK→HDR: the 25th rise.
- ANY→HDR: the clear input is low.

The register bank has eight 16-bit words. Word 0 is the configuration register. A clear pulse does not change it. Only the synchronous reset clears it.

Top module: `srl_target`

## Requirements
- R1: Frame bit order is D0 first. D0 is the direction flag (1 = read, 0 = write). D1..D7 are the address, most significant bit first. D8..D23 are the data word, most significant bit first.
- R2: The header bits D0..D7 are sampled on rising strobe edges in every frame. In a write frame, D8..D23 are also sampled on rising edges.
- R3: In a read frame, the falling strobe edge after the eighth rising edge puts bit 15 of the addressed register on the data output. Each later falling edge presents the next lower bit, so the output holds bit 0 after the 23rd rising edge's falling edge. The data input is ignored during D8..D23 of a read and cannot change any register.
- R4: A written register keeps its old value until the 25th rising strobe edge. A frame with fewer edges writes nothing.
- R5: The bit counter counts rising edges from 0 to 24. The 25th rising edge returns it to 0, so frames can follow each other back to back with no clear between them.
- R6: While the clear input is low, the counter, the shift registers, the address hold and the direction flag return to their idle values, and the sequencer returns to the header state. A clear aborts a pending write and leaves every register word intact, including the configuration register at address 0.
- R7: The bank has addresses 0..7. A read of address 8 or above returns 0. A write to address 8 or above changes nothing.
- R8: The synchronous active-high reset clears all register words, including the configuration register, and drives the data output to 0.
- R9: The data output changes only in response to a falling strobe edge, a clear or a reset. During write frames it stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, clears everything |
| clr_n | input | 1 | Active-low sequence clear, spares the register words |
| stb | input | 1 | Host strobe, asynchronous to clk |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial read data to host |

## Verification
The hardest case to reach is a frame that has carried all of its data bits but not its acknowledge edge. From the outside it looks the same as a completed write until the register is read back. The bench stops a frame after 24 rising edges, and another after 20, then pulses clear. It then reads the target word with a fresh read frame, which shows both that the write did not happen and that the configuration word survived. Read frames also drive an alternating pattern on the data input during the data bits, so any leak of the input into a register shows up in a later read.

// File: rtl/srl_pkg.sv
package srl_pkg;
    typedef enum logic [1:0] {
        ST_HDR = 2'd0,
        ST_WR  = 2'd1,
        ST_RD  = 2'd2,
        ST_ACK = 2'd3
    } srl_state_e;
endpackage

// File: rtl/srl_edge_sync.sv
module srl_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
    assign fall = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/srl_reg_bank.sv
module srl_reg_bank #(
    parameter int AW   = 7,
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] cfg_word
);
    localparam int IW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [DW-1:0] words [NREG];
    logic          in_range;

    assign in_range = (addr < AW'(NREG));

    for (genvar g = 0; g < NREG; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (wr_en && in_range && addr == AW'(g)) begin
                words[g] <= wr_word;
            end
        end
    end

    assign rd_word  = in_range ? words[addr[IW-1:0]] : '0;
    assign cfg_word = words[0];
endmodule

// File: rtl/srl_frame_fsm.sv
module srl_frame_fsm
    import srl_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_n,
    input  logic          rise,
    input  logic          fall,
    input  logic          sdi,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_q,
    output logic          wr_en,
    output logic [DW-1:0] wr_word,
    output logic          sdo,
    output logic [CW-1:0] cnt,
    output srl_state_e    state,
    output logic          rd_flag
);
    localparam int HDR_BITS   = 1 + AW;
    localparam int FRAME_BITS = HDR_BITS + DW;

    srl_state_e    nxt;
    logic [AW-1:0] ash;
    logic [DW-1:0] wsh;
    logic [DW-1:0] rsh;
    logic          idle;

    assign idle = rst || !clr_n;

    // state register
    always_ff @(posedge clk) begin
        if (idle) state <= ST_HDR;
        else      state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_HDR: if (rise && cnt == CW'(HDR_BITS - 1))
                        nxt = rd_flag ? ST_RD : ST_WR;
            ST_WR:  if (rise && cnt == CW'(FRAME_BITS - 1)) nxt = ST_ACK;
            ST_RD:  if (rise && cnt == CW'(FRAME_BITS - 1)) nxt = ST_ACK;
            ST_ACK: if (rise) nxt = ST_HDR;
            default: nxt = ST_HDR;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (idle) begin
            cnt     <= '0;
            ash     <= '0;
            addr_q  <= '0;
            wsh     <= '0;
            rsh     <= '0;
            rd_flag <= 1'b0;
            sdo     <= 1'b0;
        end else begin
            if (rise) begin
                if (state == ST_ACK) begin
                    cnt     <= '0;
                    rd_flag <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                if (state == ST_HDR) begin
                    if (cnt == '0) begin
                        rd_flag <= sdi;
                    end else begin
                        ash <= {ash[AW-2:0], sdi};
                        if (cnt == CW'(HDR_BITS - 1))
                            addr_q <= {ash[AW-2:0], sdi};
                    end
                end
                if (state == ST_WR)
                    wsh <= {wsh[DW-2:0], sdi};
            end
            if (fall) begin
                if (state == ST_RD) begin
                    if (cnt == CW'(HDR_BITS)) begin
                        sdo <= rd_word[DW-1];
                        rsh <= {rd_word[DW-2:0], 1'b0};
                    end else begin
                        sdo <= rsh[DW-1];
                        rsh <= {rsh[DW-2:0], 1'b0};
                    end
                end else begin
                    sdo <= 1'b0;
                end
            end
        end
    end

    assign wr_en   = !idle && rise && state == ST_ACK && !rd_flag;
    assign wr_word = wsh;
endmodule

// File: rtl/srl_target.sv
module srl_target
    import srl_pkg::*;
#(
    parameter int AW   = 7,
    parameter int DW   = 16,
    parameter int NREG = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_n,
    input  logic stb,
    input  logic sdi,
    output logic sdo
);
    localparam int FRAME_BITS = 1 + AW + DW;
    localparam int CW         = $clog2(FRAME_BITS + 1);

    logic          rise;
    logic          fall;
    logic [AW-1:0] addr_q;
    logic          wr_en;
    logic [DW-1:0] wr_word;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] cfg_word;
    logic [CW-1:0] cnt;
    srl_state_e    state;
    logic          rd_flag;

    srl_edge_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .pin (stb),
        .rise(rise),
        .fall(fall)
    );

    srl_frame_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .rise   (rise),
        .fall   (fall),
        .sdi    (sdi),
        .rd_word(rd_word),
        .addr_q (addr_q),
        .wr_en  (wr_en),
        .wr_word(wr_word),
        .sdo    (sdo),
        .cnt    (cnt),
        .state  (state),
        .rd_flag(rd_flag)
    );

    srl_reg_bank #(.AW(AW), .DW(DW), .NREG(NREG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr_q),
        .wr_word (wr_word),
        .rd_word (rd_word),
        .cfg_word(cfg_word)
    );
endmodule

// File: rtl/srl_target_chk.sv
module srl_target_chk
    import srl_pkg::*;
#(
    parameter int CW         = 5,
    parameter int DW         = 16,
    parameter int FRAME_BITS = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          clr_n,
    input logic          fall,
    input logic          sdo,
    input logic          wr_en,
    input logic          rd_flag,
    input logic [CW-1:0] cnt,
    input srl_state_e    state,
    input logic [DW-1:0] cfg_word
);
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(FRAME_BITS));

    p_ack_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        state == ST_ACK |-> cnt == CW'(FRAME_BITS));

    p_wr_restarts_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (state == ST_HDR && cnt == '0));

    p_clear_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (state == ST_HDR && cnt == '0 && !rd_flag));

    p_cfg_kept_r6: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_word));

    p_rd_state_r3: assert property (@(posedge clk) disable iff (rst)
        state == ST_RD |-> rd_flag);

    p_sdo_on_fall_r9: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !fall) |=> $stable(sdo));
endmodule

bind srl_target srl_target_chk #(
    .CW(CW), .DW(DW), .FRAME_BITS(FRAME_BITS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr_n   (clr_n),
    .fall    (fall),
    .sdo     (sdo),
    .wr_en   (wr_en),
    .rd_flag (rd_flag),
    .cnt     (cnt),
    .state   (state),
    .cfg_word(cfg_word)
);

// File: tb/sim_srl_target.sv
`timescale 1ns/1ps
module sim_srl_target;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1;
    logic stb = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    srl_target u0 (
        .clk  (clk),
        .rst  (rst),
        .clr_n(clr_n),
        .stb  (stb),
        .sdi  (sdi),
        .sdo  (sdo)
    );

    // {rw, addr[6:0], data[15:0], expected[15:0]}
    localparam int NV = 10;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 7'd0, 16'h1234, 16'h0000},
        {1'b1, 7'd0, 16'h0000, 16'h1234},
        {1'b0, 7'd5, 16'hBEEF, 16'h0000},
        {1'b1, 7'd5, 16'h0000, 16'hBEEF},
        {1'b0, 7'd9, 16'h5555, 16'h0000},
        {1'b1, 7'd9, 16'h0000, 16'h0000},
        {1'b0, 7'd7, 16'h8001, 16'h0000},
        {1'b1, 7'd7, 16'h0000, 16'h8001},
        {1'b1, 7'd0, 16'h0000, 16'h1234},
        {1'b1, 7'd5, 16'h0000, 16'hBEEF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends nrise rising strobe edges of a frame; returns the read word and
    // whether sdo stayed at 0 throughout.
    task automatic frame(input logic rw, input logic [6:0] addr, input logic [15:0] data,
                         input int nrise, output logic [15:0] rd, output logic sdo_quiet);
        rd = '0;
        sdo_quiet = 1'b1;
        for (int i = 0; i < nrise; i++) begin
            if (i == 0)       sdi = rw;
            else if (i < 8)   sdi = addr[7 - i];
            else if (i < 24)  sdi = rw ? i[0] : data[23 - i];
            else              sdi = 1'b0;
            tick(1);
            stb = 1'b1;
            tick(4);
            stb = 1'b0;
            tick(4);
            if (sdo !== 1'b0) sdo_quiet = 1'b0;
            if (rw && i >= 7 && i <= 22) rd[22 - i] = sdo;
        end
    endtask

    task automatic pulse_clr();
        clr_n = 1'b0;
        tick(2);
        clr_n = 1'b1;
        tick(2);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] rd;
        logic        quiet;
        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R8 sdo after reset", {15'd0, sdo}, 16'h0000);

        // table walk: R1 R2 R3 R5 R7 R9
        for (int v = 0; v < NV; v++) begin
            frame(VEC[v][39], VEC[v][38:32], VEC[v][31:16], 25, rd, quiet);
            if (VEC[v][39]) chk("R1/R3/R7 read word", rd, VEC[v][15:0]);
            else            chk("R9 sdo quiet in write", {15'd0, quiet}, 16'h0001);
        end

        // R2: write with mixed bits, back-to-back read (R5)
        frame(1'b0, 7'd3, 16'h0F0F, 25, rd, quiet);
        frame(1'b1, 7'd3, 16'h0000, 25, rd, quiet);
        chk("R2/R5 back-to-back read", rd, 16'h0F0F);

        // R4/R6: partial write (20 edges) aborted by clear
        frame(1'b0, 7'd3, 16'hAAAA, 20, rd, quiet);
        pulse_clr();
        frame(1'b1, 7'd3, 16'h0000, 25, rd, quiet);
        chk("R6 partial write aborted", rd, 16'h0F0F);

        // R4/R6: full data but no acknowledge edge to config register
        frame(1'b0, 7'd0, 16'hFFFF, 24, rd, quiet);
        pulse_clr();
        frame(1'b1, 7'd0, 16'h0000, 25, rd, quiet);
        chk("R4 no commit without 25th edge, R6 cfg kept", rd, 16'h1234);

        // R3: sdi toggled during read did not disturb register 5
        frame(1'b1, 7'd5, 16'h0000, 25, rd, quiet);
        chk("R3 sdi ignored during read", rd, 16'hBEEF);

        // R6: clear in the middle of a read, then normal read
        frame(1'b1, 7'd7, 16'h0000, 12, rd, quiet);
        pulse_clr();
        chk("R9 sdo cleared by clear", {15'd0, sdo}, 16'h0000);
        frame(1'b1, 7'd7, 16'h0000, 25, rd, quiet);
        chk("R6 read after mid-read clear", rd, 16'h8001);

        // R8: reset clears everything including config
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(2);
        frame(1'b1, 7'd0, 16'h0000, 25, rd, quiet);
        chk("R8 cfg cleared by reset", rd, 16'h0000);
        frame(1'b1, 7'd5, 16'h0000, 25, rd, quiet);
        chk("R8 word cleared by reset", rd, 16'h0000);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule